// File: doc/BRIEF.md
# PWM Pair Boundary Dead-Time Inserter

This block sits behind a center-aligned PWM comparator and drives one complementary pair of gate signals: one for the high-side switch and one for the low-side switch. Both are active low. The comparator supplies the level it wants on each signal every clock. The block passes those levels through one register stage. At each period boundary it checks whether both signals would change state on the same edge. This happens when the pair enters or leaves full-ON or full-OFF operation, where one half-period keeps the high side on or off throughout.

When such a double toggle is seen, the signal moving into its ON state is held OFF for twice the programmed dead time. The signal moving OFF changes at once. When the hold ends, the delayed signal turns on only if its wanted level is still ON at that moment. In single update mode only the period-start boundary is examined. In double update mode the mid-period boundary is examined as well.

Top module: `pwm_pair_dt_gate`

## Requirements
- R1: After reset, and until the first clock edge that samples `sync` high, both `out_hi_n` and `out_lo_n` are 1 (OFF), whatever the wanted levels are.
- R2: Outside a hold, each output equals its wanted level (`want_hi_n`, `want_lo_n`; 0 = ON, 1 = OFF) sampled at the previous rising clock edge, one register of latency.
- R3: A boundary is a clock edge that samples `sync` high. With `dbl_upd` = 1 every such edge is a boundary. With `dbl_upd` = 0 only edges with `half_sel` = 0 (period start) count; a sync with `half_sel` = 1 in that mode never starts a hold.
- R4: A double toggle is a boundary at which both wanted levels differ from the levels sampled one clock earlier. Only a double toggle with a nonzero `dead_time` starts a hold.
- R5: During a hold, the signal whose new wanted level is 0 stays 1 on the boundary edge and on the following 2×`dead_time`−1 edges. From edge 2×`dead_time` after the boundary it follows its wanted level again, so it stays OFF if that level has returned to 1.
- R6: At a double toggle, the signal whose new wanted level is 1 goes OFF on the boundary edge itself.
- R7: A boundary at which only one wanted level changes, or neither does, inserts no delay.
- R8: With `dead_time` = 0 a double toggle inserts no delay.
- R9: A later boundary that is not itself a qualifying double toggle cancels a running hold on its own edge. A qualifying one restarts the hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sync | input | 1 | One-cycle pulse marking a half-period boundary |
| half_sel | input | 1 | 0 = boundary starts the first half, 1 = starts the second half |
| dbl_upd | input | 1 | 1 = double update mode, 0 = single update mode |
| dead_time | input | 10 | Dead-time count in clocks, unsigned |
| want_hi_n | input | 1 | Wanted high-side level, active low |
| want_lo_n | input | 1 | Wanted low-side level, active low |
| out_hi_n | output | 1 | Gated high-side output, active low |
| out_lo_n | output | 1 | Gated low-side output, active low |

## Verification
Each output is due one edge after the stimulus it follows. A turn-on delayed by a hold falls exactly 2×`dead_time` edges after the boundary edge, and the bench checks both the last held cycle and the first released cycle. Inputs change on the falling edge and outputs are read on the next falling edge, so every check sees exactly one rising edge's worth of update. The reference model records the edge number at which a hold releases, rather than counting down, and compares against it every cycle under directed and random waveforms.

// File: rtl/pdt_pkg.sv
// Package: shared lane indexing and widths for the pair dead-time inserter.
// Assumes exactly one complementary pair (high side and low side).
package pdt_pkg;
    localparam int unsigned LANES   = 2;
    localparam int unsigned LANE_HI = 0;
    localparam int unsigned LANE_LO = 1;
    typedef logic [LANES-1:0] lane_vec_t;
endpackage

// File: rtl/pdt_boundary.sv
// Boundary detector: keeps the wanted levels of the previous cycle, decides
// whether the current sync pulse is a boundary for the active update mode,
// and flags which lanes change state at that boundary.
// Assumes sync is a single-cycle pulse synchronous to clk.
module pdt_boundary
    import pdt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sync_i,
    input  logic      half_i,
    input  logic      dbl_i,
    input  lane_vec_t want_i,
    output logic      started_o,
    output logic      started_nxt_o,
    output logic      bnd_o,
    output lane_vec_t toggle_o
);
    lane_vec_t prev_q;
    logic      started_q;

    // Remember last cycle's wanted levels; OFF after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= want_i;
    end

    // Note that the first sync pulse has arrived.
    always_ff @(posedge clk) begin
        if (!rst_n)      started_q <= 1'b0;
        else if (sync_i) started_q <= 1'b1;
    end

    // Qualify the boundary and flag per-lane changes across it.
    always_comb begin
        bnd_o    = sync_i && (dbl_i || !half_i);
        toggle_o = bnd_o ? (want_i ^ prev_q) : '0;
    end

    assign started_o     = started_q;
    assign started_nxt_o = started_q | sync_i;

    AST_START_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        started_q |=> started_q); // R1
endmodule

// File: rtl/pdt_hold_timer.sv
// Hold timer: on a boundary where every lane toggles and the dead time is
// nonzero, forces the lanes turning ON to stay OFF for 2*dead clock edges,
// the boundary edge included. Any other boundary ends a running hold.
// Assumes dead_i is stable while a hold is loaded (sampled at the boundary).
module pdt_hold_timer
    import pdt_pkg::*;
#(
    parameter int unsigned DT_W = 10
)(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bnd_i,
    input  lane_vec_t       toggle_i,
    input  lane_vec_t       want_i,
    input  logic [DT_W-1:0] dead_i,
    output lane_vec_t       force_o
);
    localparam int unsigned CNT_W = DT_W + 1;

    logic [CNT_W-1:0] span;
    logic             load;
    logic             active_q;
    logic [CNT_W-1:0] cnt_q;
    lane_vec_t        sel_q;

    // Doubled dead time and the decision to start a hold.
    always_comb begin
        span = {dead_i, 1'b0};
        load = bnd_i && (&toggle_i) && (span != '0);
    end

    // Count the remaining held edges after the boundary edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            sel_q    <= '0;
        end else if (bnd_i) begin
            active_q <= load;
            cnt_q    <= span - CNT_W'(1);
            sel_q    <= ~want_i;
        end else if (active_q) begin
            if (cnt_q == '0) active_q <= 1'b0;
            else             cnt_q    <= cnt_q - CNT_W'(1);
        end
    end

    // Lanes forced OFF on the current edge.
    always_comb begin
        if (load)                          force_o = ~want_i;
        else if (active_q && cnt_q != '0 && !bnd_i) force_o = sel_q;
        else                               force_o = '0;
    end

    AST_HOLD_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && cnt_q != '0 && !bnd_i) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R5
    AST_NO_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd_i && dead_i == '0) |=> !active_q); // R8
    AST_BND_ENDS_OLD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd_i && !(&toggle_i)) |=> !active_q); // R9
endmodule

// File: rtl/pdt_out_stage.sv
// Output stage: one register per lane; drives OFF before the first sync or
// while the hold timer forces the lane, otherwise the wanted level.
// Assumes active-low outputs (1 = OFF).
module pdt_out_stage
    import pdt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      started_nxt_i,
    input  lane_vec_t force_i,
    input  lane_vec_t want_i,
    output lane_vec_t out_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Register this lane's gated output.
        always_ff @(posedge clk) begin
            if (!rst_n)                           out_o[g] <= 1'b1;
            else if (!started_nxt_i || force_i[g]) out_o[g] <= 1'b1;
            else                                  out_o[g] <= want_i[g];
        end
    end
endmodule

// File: rtl/pwm_pair_dt_gate.sv
// Top: boundary dead-time inserter for one complementary PWM pair.
// Assumes the wanted levels come from a center-aligned comparator and that
// sync marks each half-period boundary with half_sel naming the new half.
module pwm_pair_dt_gate
    import pdt_pkg::*;
#(
    parameter int unsigned DT_W = 10
)(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sync,
    input  logic            half_sel,
    input  logic            dbl_upd,
    input  logic [DT_W-1:0] dead_time,
    input  logic            want_hi_n,
    input  logic            want_lo_n,
    output logic            out_hi_n,
    output logic            out_lo_n
);
    lane_vec_t want;
    lane_vec_t toggle;
    lane_vec_t force_off;
    lane_vec_t out;
    logic      started;
    logic      started_nxt;
    logic      bnd;

    assign want[LANE_HI] = want_hi_n;
    assign want[LANE_LO] = want_lo_n;

    pdt_boundary u_bnd (
        .clk           (clk),
        .rst_n         (rst_n),
        .sync_i        (sync),
        .half_i        (half_sel),
        .dbl_i         (dbl_upd),
        .want_i        (want),
        .started_o     (started),
        .started_nxt_o (started_nxt),
        .bnd_o         (bnd),
        .toggle_o      (toggle)
    );

    pdt_hold_timer #(.DT_W(DT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .bnd_i    (bnd),
        .toggle_i (toggle),
        .want_i   (want),
        .dead_i   (dead_time),
        .force_o  (force_off)
    );

    pdt_out_stage u_out (
        .clk           (clk),
        .rst_n         (rst_n),
        .started_nxt_i (started_nxt),
        .force_i       (force_off),
        .want_i        (want),
        .out_o         (out)
    );

    assign out_hi_n = out[LANE_HI];
    assign out_lo_n = out[LANE_LO];

    AST_IDLE_UNTIL_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (!started && !sync) |=> (out_hi_n && out_lo_n)); // R1
    AST_ON_DEFERRED: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd && (&toggle) && dead_time != '0 && !want_hi_n) |=> out_hi_n); // R5
    AST_NO_SHARED_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd && (&toggle) && dead_time != '0) |=> (out_hi_n || out_lo_n)); // R4
endmodule

// File: tb/pwm_pair_dt_gate_bench.sv
module pwm_pair_dt_gate_bench;
    logic       clk = 1'b0, rst_n = 1'b0, sync = 1'b0, half_sel = 1'b0, dbl_upd = 1'b1;
    logic [9:0] dead_time = 10'd2;
    logic       want_hi_n = 1'b1, want_lo_n = 1'b1;
    logic       out_hi_n, out_lo_n;
    int         checks = 0, fails = 0;

    always #5 clk = ~clk;

    pwm_pair_dt_gate u_pwm_pair_dt_gate (
        .clk(clk), .rst_n(rst_n), .sync(sync), .half_sel(half_sel), .dbl_upd(dbl_upd),
        .dead_time(dead_time), .want_hi_n(want_hi_n), .want_lo_n(want_lo_n),
        .out_hi_n(out_hi_n), .out_lo_n(out_lo_n)
    );

    // Reference: release edge number stored when a hold begins.
    int unsigned n_edge = 0, rel_at = 0;
    logic m_ph = 1, m_pl = 1, m_st = 0, m_fh = 0, m_fl = 0, e_hi = 1, e_lo = 1;

    always @(posedge clk) begin
        n_edge++;
        if (!rst_n) begin
            m_ph = 1; m_pl = 1; m_st = 0; m_fh = 0; m_fl = 0; rel_at = 0; e_hi = 1; e_lo = 1;
        end else begin
            if (sync && (dbl_upd || !half_sel)) begin
                if (want_hi_n != m_ph && want_lo_n != m_pl && dead_time != 0) begin
                    rel_at = n_edge + 2 * dead_time;
                    m_fh = !want_hi_n; m_fl = !want_lo_n;
                end else rel_at = n_edge;
            end
            if (sync) m_st = 1;
            e_hi = (!m_st || (m_fh && n_edge < rel_at)) ? 1'b1 : want_hi_n;
            e_lo = (!m_st || (m_fl && n_edge < rel_at)) ? 1'b1 : want_lo_n;
            m_ph = want_hi_n; m_pl = want_lo_n;
        end
    end

    task automatic chk(input string req);
        checks++;
        if (out_hi_n !== e_hi || out_lo_n !== e_lo) begin
            fails++;
            $display("FAIL %s: got hi=%b lo=%b expected hi=%b lo=%b", req, out_hi_n, out_lo_n, e_hi, e_lo);
        end
    endtask

    task automatic chk_exp(input string req, input logic eh, input logic el);
        checks++;
        if (out_hi_n !== eh || out_lo_n !== el) begin
            fails++;
            $display("FAIL %s: got hi=%b lo=%b expected hi=%b lo=%b", req, out_hi_n, out_lo_n, eh, el);
        end
    endtask

    task automatic cyc(input logic s, input logic h, input logic wh, input logic wl);
        sync = s; half_sel = h; want_hi_n = wh; want_lo_n = wl;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) cyc(0, 0, 0, 0);
        chk_exp("R1 reset", 1, 1);
        rst_n = 1'b1;
        cyc(0, 0, 0, 1); chk_exp("R1 before sync", 1, 1);
        cyc(1, 0, 0, 1); chk_exp("R7 no toggle", 0, 1);
        cyc(0, 0, 1, 0); chk_exp("R2 follow", 1, 0);
        // double toggle at mid-period, dead_time 2 -> 4 held edges
        cyc(1, 1, 0, 1); chk_exp("R6 off now", 1, 1); chk_exp("R4 swap", 1, 1);
        repeat (3) begin cyc(0, 1, 0, 1); chk_exp("R5 held", 1, 1); end
        cyc(0, 1, 0, 1); chk_exp("R5 release", 0, 1);
        // wanted level withdrawn during hold
        cyc(0, 1, 1, 0);
        cyc(1, 0, 0, 1); chk("R5 start");
        cyc(0, 0, 1, 1); chk("R5 withdrawn");
        repeat (4) begin cyc(0, 0, 1, 1); chk_exp("R5 stays off", 1, 1); end
        // single mode: mid-period sync is not a boundary
        dbl_upd = 1'b0;
        cyc(0, 1, 1, 0);
        cyc(1, 1, 0, 1); chk_exp("R3 single mid", 0, 1);
        cyc(0, 0, 1, 0);
        cyc(1, 0, 0, 1); chk_exp("R3 single start", 1, 1);
        repeat (4) cyc(0, 0, 0, 1);
        chk_exp("R3 released", 0, 1);
        // zero dead time
        dbl_upd = 1'b1; dead_time = 10'd0;
        cyc(0, 0, 1, 0);
        cyc(1, 0, 0, 1); chk_exp("R8 zero dt", 0, 1);
        // cancel by later boundary
        dead_time = 10'd3;
        cyc(0, 0, 1, 0);
        cyc(1, 0, 0, 1); chk_exp("R9 hold", 1, 1);
        cyc(0, 0, 0, 1); chk_exp("R9 hold", 1, 1);
        cyc(1, 1, 0, 1); chk_exp("R9 cancel", 0, 1);
        // random waveforms
        for (int p = 0; p < 200; p++) begin
            dbl_upd = 1'($urandom % 2);
            dead_time = 10'($urandom % 4);
            for (int h = 0; h < 2; h++) begin
                int kind = $urandom % 3;
                int a = 1 + ($urandom % 3);
                int b = a + 1 + ($urandom % 3);
                for (int i = 0; i < 8; i++) begin
                    logic wh = (kind == 0) ? 1'b0 : (kind == 1) ? 1'b1 : ((i >= a && i < b) ? 1'b0 : 1'b1);
                    logic wl = ($urandom % 8 == 0) ? 1'b1 : !wh;
                    cyc(i == 0, 1'(h), wh, wl);
                    chk("R2 random");
                end
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule